// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

This block sits between a single-request front end and a shared DRAM command bus that serves several ranks. It accepts one read or write request at a time, each naming a rank, bank, row and column. It keeps a table of which row is open in every bank of every rank, and uses that table to pick the shortest legal command sequence for the request. If the requested row is already open, only a column command is issued. If a different row is open, that row is closed, the requested row is opened, and then the column command is issued. If the bank is closed, the row is opened and the column command follows.

A free-running interval timer forces refresh. Ranks take turns, one rank per interval. Refresh first closes every bank of the target rank, then issues the refresh command, and then waits a recovery gap. Each column command is followed by a window of burst beats in which `burst_valid` is high. Before the external initialisation flag is raised, the sequencer keeps the bus idle.

Top module: `dseq_top`

## Requirements
- R1: Commands use active-low `{ras_n,cas_n,we_n}` codes: activate 011, read 101, write 100, precharge 010, refresh 001. A no-op is 111 with every `cs_n` bit high.
- R2: A request to a closed bank produces an activate one cycle after acceptance, with `ba` = bank and `addr` = row. The column command follows exactly T_RCD cycles later, with `addr` = column.
- R3: A request whose row differs from the bank's open row produces a single-bank precharge one cycle after acceptance (`addr` bit 10 low, `addr` = 0). An activate follows T_RP cycles later, and the column command T_RCD cycles after the activate.
- R4: A request whose row equals the bank's open row produces only a column command, one cycle after acceptance.
- R5: Every non-no-op command has exactly one `cs_n` bit low, at the request's (or refresh target's) rank index. Open rows are tracked separately for each rank.
- R6: Refresh is requested every REF_INT cycles after `init_done`. It is served as a precharge of all banks of the target rank (`addr` bit 10 high), followed T_RP cycles later by a refresh to the same rank. The target rank starts at 0 and alternates. After a refresh, every bank of that rank is treated as closed.
- R7: No activate is issued fewer than T_RFC cycles after a refresh.
- R8: `req_ready` is high only when the sequencer is idle, initialised and has no refresh pending. It stays low from acceptance through the last burst beat.
- R9: During reset and until `init_done` is first high, only no-ops are issued and `req_ready` stays low.
- R10: `burst_valid` is high for exactly BURST cycles, starting the cycle after each read or write command.
- R11: A pending refresh is served before any new request. Its all-bank precharge appears within 40 cycles of the interval boundary, even under a continuous stream of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Device initialisation complete; held high once raised |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a cycle where valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rank | input | RANKW (1) | Target rank |
| req_bank | input | BANKW (3) | Target bank |
| req_row | input | ROWW (14) | Target row |
| req_col | input | COLW (10) | Burst start column |
| cs_n | output | NRANK (2) | Per-rank chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANKW (3) | Bank address |
| addr | output | ROWW (14) | Row, column or all-bank flag (bit 10) |
| burst_valid | output | 1 | Data beat window of the current burst |

## Verification
The bench keeps the default geometry of two ranks, eight banks, 14-bit rows, T_RCD = 4, T_RP = 4, T_RFC = 20 and BURST = 8. It shortens REF_INT to 300 cycles. With that interval, a stream of a little over a hundred requests crosses several refresh boundaries. Refreshes therefore land while requests are waiting, both ranks get refreshed, and rows that were open before a refresh must be reopened afterwards.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF
  } dcmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_WRP, S_ACT, S_WRCD, S_COL, S_BURST,
    S_RPALL, S_RWRP, S_REF, S_RWFC
  } dstate_e;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] cmd_pins(dcmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_PRE: return 3'b010;
      CMD_REF: return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/dseq_openrow.sv
module dseq_openrow #(
  parameter int NRANK = 2,
  parameter int NBANK = 8,
  parameter int ROWW  = 14,
  parameter int RANKW = 1,
  parameter int BANKW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RANKW-1:0] lk_rank,
  input  logic [BANKW-1:0] lk_bank,
  output logic             lk_vld,
  output logic [ROWW-1:0]  lk_row,
  input  logic             set_en,
  input  logic [RANKW-1:0] set_rank,
  input  logic [BANKW-1:0] set_bank,
  input  logic [ROWW-1:0]  set_row,
  input  logic             clr_en,
  input  logic [RANKW-1:0] clr_rank
);
  localparam int NENT = NRANK * NBANK;
  localparam int IDXW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [NENT-1:0] vld_all;
  logic [ROWW-1:0] row_all [NENT];
  logic [IDXW-1:0] lk_idx;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    localparam int RK = e / NBANK;
    localparam int BK = e % NBANK;
    logic            v_q;
    logic [ROWW-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= '0;
      end else if (clr_en && int'(clr_rank) == RK) begin
        v_q <= 1'b0;
      end else if (set_en && int'(set_rank) == RK && int'(set_bank) == BK) begin
        v_q <= 1'b1;
        r_q <= set_row;
      end
    end
    assign vld_all[e] = v_q;
    assign row_all[e] = r_q;
  end

  assign lk_idx = IDXW'(int'(lk_rank) * NBANK + int'(lk_bank));
  assign lk_vld = vld_all[lk_idx];
  assign lk_row = row_all[lk_idx];

endmodule

// File: rtl/dseq_reftimer.sv
module dseq_reftimer #(
  parameter int REF_INT = 7800,
  parameter int NRANK   = 2,
  parameter int RANKW   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ack,
  output logic             pending,
  output logic [RANKW-1:0] target
);
  localparam int CW = $clog2(REF_INT + 1);

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = run && (cnt_q == CW'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
      target  <= '0;
    end else begin
      if (run) cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
      if (ack) target <= (int'(target) == NRANK - 1) ? '0 : target + 1'b1;
    end
  end

endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
#(
  parameter int NRANK   = 2,
  parameter int NBANK   = 8,
  parameter int ROWW    = 14,
  parameter int COLW    = 10,
  parameter int T_RCD   = 4,
  parameter int T_RP    = 4,
  parameter int T_RFC   = 20,
  parameter int BURST   = 8,
  parameter int REF_INT = 7800,
  localparam int RANKW  = (NRANK > 1) ? $clog2(NRANK) : 1,
  localparam int BANKW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [RANKW-1:0] req_rank,
  input  logic [BANKW-1:0] req_bank,
  input  logic [ROWW-1:0]  req_row,
  input  logic [COLW-1:0]  req_col,
  output logic [NRANK-1:0] cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BANKW-1:0] ba,
  output logic [ROWW-1:0]  addr,
  output logic             burst_valid
);
  localparam int AP_BIT = 10;
  localparam int CNTW   = $clog2(T_RFC + T_RP + T_RCD + BURST) + 1;

  // wait states last T-1 cycles, so the next command lands T after the last one
  function automatic logic [CNTW-1:0] gap_load(int t);
    return CNTW'(t - 2);
  endfunction

  dstate_e          st_q;
  logic [CNTW-1:0]  cnt_q;
  logic             q_wr;
  logic [RANKW-1:0] q_rank;
  logic [BANKW-1:0] q_bank;
  logic [ROWW-1:0]  q_row;
  logic [COLW-1:0]  q_col;

  logic             lk_vld;
  logic [ROWW-1:0]  lk_row;
  logic             ref_pend;
  logic [RANKW-1:0] ref_rank;
  dcmd_e            cmd;
  logic [RANKW-1:0] cmd_rank;

  // named events for the checker
  logic acc, cmd_act, cmd_pre, cmd_col, cmd_ref, row_hit;

  assign req_ready = init_done && (st_q == S_IDLE) && !ref_pend;
  assign acc       = req_valid && req_ready;
  assign row_hit   = lk_vld && (lk_row == req_row);

  dseq_openrow #(
    .NRANK(NRANK), .NBANK(NBANK), .ROWW(ROWW), .RANKW(RANKW), .BANKW(BANKW)
  ) u_rows (
    .clk(clk), .rst_n(rst_n),
    .lk_rank(req_rank), .lk_bank(req_bank), .lk_vld(lk_vld), .lk_row(lk_row),
    .set_en(cmd_act), .set_rank(q_rank), .set_bank(q_bank), .set_row(q_row),
    .clr_en(cmd_ref), .clr_rank(ref_rank)
  );

  dseq_reftimer #(.REF_INT(REF_INT), .NRANK(NRANK), .RANKW(RANKW)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(init_done), .ack(cmd_ref),
    .pending(ref_pend), .target(ref_rank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      q_wr   <= 1'b0;
      q_rank <= '0;
      q_bank <= '0;
      q_row  <= '0;
      q_col  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (init_done && ref_pend) begin
            st_q <= S_RPALL;
          end else if (acc) begin
            q_wr   <= req_write;
            q_rank <= req_rank;
            q_bank <= req_bank;
            q_row  <= req_row;
            q_col  <= req_col;
            st_q   <= row_hit ? S_COL : (lk_vld ? S_PRE : S_ACT);
          end
        end
        S_PRE:   begin cnt_q <= gap_load(T_RP);  st_q <= S_WRP;  end
        S_ACT:   begin cnt_q <= gap_load(T_RCD); st_q <= S_WRCD; end
        S_COL:   begin cnt_q <= CNTW'(BURST - 1); st_q <= S_BURST; end
        S_RPALL: begin cnt_q <= gap_load(T_RP);  st_q <= S_RWRP; end
        S_REF:   begin cnt_q <= gap_load(T_RFC); st_q <= S_RWFC; end
        S_WRP, S_WRCD, S_BURST, S_RWRP, S_RWFC: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            case (st_q)
              S_WRP:   st_q <= S_ACT;
              S_WRCD:  st_q <= S_COL;
              S_RWRP:  st_q <= S_REF;
              default: st_q <= S_IDLE;
            endcase
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      S_PRE, S_RPALL: cmd = CMD_PRE;
      S_ACT:          cmd = CMD_ACT;
      S_COL:          cmd = q_wr ? CMD_WR : CMD_RD;
      S_REF:          cmd = CMD_REF;
      default:        cmd = CMD_NOP;
    endcase
  end

  assign cmd_act = (cmd == CMD_ACT);
  assign cmd_pre = (cmd == CMD_PRE);
  assign cmd_col = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign cmd_ref = (cmd == CMD_REF);
  assign cmd_rank = (st_q == S_RPALL || st_q == S_REF) ? ref_rank : q_rank;

  always_comb begin
    cs_n = '1;
    if (cmd != CMD_NOP) cs_n[cmd_rank] = 1'b0;
  end

  assign {ras_n, cas_n, we_n} = cmd_pins(cmd);

  always_comb begin
    ba   = '0;
    addr = '0;
    case (st_q)
      S_PRE:   ba = q_bank;
      S_ACT:   begin ba = q_bank; addr = q_row; end
      S_COL:   begin ba = q_bank; addr = ROWW'(q_col); end
      S_RPALL: addr[AP_BIT] = 1'b1;
      default: ;
    endcase
  end

  assign burst_valid = (st_q == S_BURST);

endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int NRANK = 2,
  parameter int T_RCD = 4,
  parameter int T_RP  = 4,
  parameter int T_RFC = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_done,
  input logic             req_ready,
  input logic             burst_valid,
  input logic [NRANK-1:0] cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             cmd_act,
  input logic             cmd_pre,
  input logic             cmd_col,
  input logic             cmd_ref
);
  logic [7:0] since_act, since_pre, since_ref;
  logic       init_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 8'hff;
      since_pre <= 8'hff;
      since_ref <= 8'hff;
      init_seen <= 1'b0;
    end else begin
      since_act <= cmd_act ? 8'd1 : (since_act == 8'hff ? since_act : since_act + 8'd1);
      since_pre <= cmd_pre ? 8'd1 : (since_pre == 8'hff ? since_pre : since_pre + 8'd1);
      since_ref <= cmd_ref ? 8'd1 : (since_ref == 8'hff ? since_ref : since_ref + 8'd1);
      if (init_done) init_seen <= 1'b1;
    end
  end

  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  a_r9_quiet_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_seen && !init_done) |-> (&cs_n && ras_n && cas_n && we_n && !req_ready));

  a_r2_act_to_col_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col |-> (since_act >= 8'(T_RCD)));

  a_r3_pre_to_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> (since_pre >= 8'(T_RP)));

  a_r6_ref_after_preall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ref |-> (since_pre == 8'(T_RP)));

  a_r7_ref_to_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> (since_ref >= 8'(T_RFC)));

  a_r8_busy_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> !req_ready);

  a_r10_burst_after_col: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col |=> burst_valid);

endmodule

bind dseq_top dseq_chk #(
  .NRANK(NRANK), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_ready(req_ready),
  .burst_valid(burst_valid), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_col(cmd_col),
  .cmd_ref(cmd_ref)
);

// File: tb/tb_dseq_top.sv
module tb_dseq_top;
  localparam int T_RCD = 4, T_RP = 4, T_RFC = 20, BURST = 8, REF_INT = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [0:0]  req_rank = '0;
  logic [2:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_ready, ras_n, cas_n, we_n, burst_valid;
  logic [1:0]  cs_n;
  logic [2:0]  ba;
  logic [13:0] addr;

  always #10 clk = ~clk;

  dseq_top #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .BURST(BURST),
             .REF_INT(REF_INT)) dut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_rank(req_rank),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .burst_valid(burst_valid)
  );

  typedef struct {
    int kind; int rank; int bank; int addr; int cyc; string rq;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, cyc = 0;
  int open_v [2][8];
  int open_r [2][8];
  int c0 = 0, nref = 0, ref_tgt = 0, preall_cyc = -1000, last_ref = -1000;
  int col_cyc = -1000;
  bit mon_on = 1'b0, finished = 1'b0;

  task automatic chk(bit ok, string r, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // command kinds: 0 nop, 1 act, 2 rd, 3 wr, 4 pre, 5 ref (R1 pin codes)
  function automatic int decode(logic r, logic c, logic w);
    case ({r, c, w})
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b001: return 5;
      3'b111: return 0;
      default: return 9;
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    int k, rk, nl, d;
    exp_t e;
    bit exp_bv;
    if (rst_n && mon_on) begin
      k  = decode(ras_n, cas_n, we_n);
      nl = $countones(~cs_n);
      rk = cs_n[0] ? 1 : 0;
      if (k == 0) begin
        if (nl != 0) chk(1'b0, "R1", "select on no-op", nl, 0);
      end else begin
        chk(nl == 1, "R5", "selects low", nl, 1);
        if (k == 4 && addr[10]) begin
          d = cyc - (c0 + (nref + 1) * REF_INT);
          chk(rk == ref_tgt, "R6", "precharge-all rank", rk, ref_tgt);
          chk(d >= 0 && d <= 40, "R11", "refresh latency", d, 0);
          preall_cyc = cyc;
        end else if (k == 5) begin
          chk(rk == ref_tgt, "R6", "refresh rank", rk, ref_tgt);
          chk(cyc == preall_cyc + T_RP, "R6", "refresh cycle", cyc, preall_cyc + T_RP);
          for (int b = 0; b < 8; b++) open_v[rk][b] = 0;
          last_ref = cyc;
          ref_tgt ^= 1;
          nref++;
        end else begin
          if (k == 1) chk(cyc - last_ref >= T_RFC, "R7", "refresh to activate", cyc - last_ref, T_RFC);
          if (q.size() == 0) begin
            chk(1'b0, "R1", "unexpected command", k, 0);
          end else begin
            e = q.pop_front();
            chk(k == e.kind, e.rq, "command kind", k, e.kind);
            chk(rk == e.rank, "R5", "rank", rk, e.rank);
            chk(int'(ba) == e.bank, e.rq, "bank", int'(ba), e.bank);
            chk(int'(addr) == e.addr, e.rq, "addr", int'(addr), e.addr);
            chk(cyc == e.cyc, e.rq, "cycle", cyc, e.cyc);
          end
          if (k == 2 || k == 3) col_cyc = cyc;
        end
      end
      exp_bv = (cyc > col_cyc) && (cyc <= col_cyc + BURST);
      if (exp_bv || burst_valid) chk(burst_valid == exp_bv, "R10", "burst window", burst_valid, exp_bv);
      if (burst_valid) chk(!req_ready, "R8", "ready during burst", req_ready, 0);
    end
  end

  task automatic push(int kind, int rk, int bk, int ad, int c, string rq);
    exp_t e;
    e.kind = kind; e.rank = rk; e.bank = bk; e.addr = ad; e.cyc = c; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic do_req(int rk, int bk, int rw, int cl, bit wr);
    int n, ck;
    ck = wr ? 3 : 2;
    do @(negedge clk); while (!req_ready);
    n = cyc;
    req_rank = 1'(rk); req_bank = 3'(bk); req_row = 14'(rw);
    req_col = 10'(cl); req_write = wr; req_valid = 1'b1;
    if (open_v[rk][bk] != 0 && open_r[rk][bk] == rw) begin
      push(ck, rk, bk, cl, n + 1, "R4");
    end else if (open_v[rk][bk] != 0) begin
      push(4, rk, bk, 0, n + 1, "R3");
      push(1, rk, bk, rw, n + 1 + T_RP, "R3");
      push(ck, rk, bk, cl, n + 1 + T_RP + T_RCD, "R3");
    end else begin
      push(1, rk, bk, rw, n + 1, "R2");
      push(ck, rk, bk, cl, n + 1 + T_RCD, "R2");
    end
    open_v[rk][bk] = 1;
    open_r[rk][bk] = rw;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 8; b++) begin open_v[r][b] = 0; open_r[r][b] = 0; end
    // R9: reset state
    repeat (4) @(negedge clk);
    chk(cs_n == 2'b11 && ras_n && cas_n && we_n, "R9", "idle bus in reset", int'(cs_n), 3);
    chk(!req_ready, "R9", "ready in reset", req_ready, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R9: request offered before init is ignored
    req_valid = 1'b1; req_row = 14'd77;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(!req_ready, "R9", "ready before init", req_ready, 0);
      chk(cs_n == 2'b11 && ras_n && cas_n && we_n, "R9", "no-op before init", int'({cs_n, ras_n, cas_n, we_n}), 31);
    end
    req_valid = 1'b0;
    c0 = cyc;
    init_done = 1'b1;
    // directed cases
    do_req(0, 0, 5, 3, 1'b0);      // R2 closed
    do_req(0, 0, 5, 7, 1'b1);      // R4 hit
    do_req(0, 0, 9, 16, 1'b0);     // R3 miss
    do_req(1, 0, 9, 24, 1'b1);     // R5 other rank, closed
    do_req(1, 7, 16383, 1023, 1'b0); // R2 max row and column
    do_req(1, 7, 16383, 8, 1'b1);  // R4 hit
    do_req(0, 0, 9, 32, 1'b0);     // R5 rank 0 still holds row 9
    // stream crossing several refresh intervals (R6, R11)
    for (int i = 0; i < 110; i++)
      do_req((i / 5) % 2, (i * 3) % 8, (i % 4 == 0) ? i : 100 + (i * 3) % 8,
             (i * 8) % 1024, i[0]);
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R2", "pending expectations", q.size(), 0);
    chk(nref >= 4, "R6", "refresh count", nref, 4);
    finish_run();
  end

endmodule